// File: doc/BRIEF.md
# LCD Frame Timing Generator

This block turns a raw oscillator clock into the timing that a row driver and its column drivers need to scan a dot-matrix LCD. A power-of-two prescaler, selected by a 3-bit field, sets the rate of the display clock. Each display clock tick produces one pulse on the shift clock output, and each pulse shifts one dot of a line. The block counts shift pulses to find where each line ends, counts lines to find where each frame ends, and toggles a frame alternation level once per frame so that the panel sees no DC drive.

Software sets the line geometry as two fields: the dots per byte minus one and the bytes per line minus one. The block clamps both into the legal range and multiplies them to get the dots per line. A third field sets the number of lines per frame, which is the duty. The run bit starts and stops the display timing. The standby bit freezes every generated output in place. The display-enable output is the registered AND of the run bit and the display-enable bit, and it is forced low while standby is set.

Top module: `lcd_frame_timer`

## Requirements
- R1: `div_sel_i` picks the shift pulse period as 2^div_sel_i oscillator cycles (000 gives 1/1 and 111 gives 1/128). With 000, `cl2_o` stays high on every cycle. With any other value, each pulse is high for one cycle.
- R2: `pitch_m1_i` holds the dots-per-byte value minus one. The values 5, 6 and 7 give 6, 7 and 8 dots. Every other value gives 8 dots.
- R3: `bytes_m1_i` holds the bytes-per-line value minus one. The resulting byte count is clamped to the range 2 to 10: a field of 0 gives 2, and a field above 9 gives 10.
- R4: `line_stb_o` is high in the same cycle as every N-th `cl2_o` pulse, where N is the product of the dots per byte and the bytes per line, at most 80.
- R5: `frame_m_o` toggles once every Nx line strobes. Nx is `duty_m1_i`+1 (a 7-bit field), clamped to the range 2 to 65.
- R6: While `run_i` is low and standby is clear, the prescaler and all counters are cleared, and `cl2_o`, `line_stb_o` and `frame_m_o` read 0 one cycle later.
- R7: While `standby_i` is high, `cl2_o`, `line_stb_o`, `frame_stb_o` and `frame_m_o` hold their values.
- R8: `disp_act_o` equals `run_i & disp_on_i & ~standby_i` delayed by one cycle, so it is low in standby.
- R9: A change of `div_sel_i` restarts the prescaler. The first pulse at the new rate appears 2^sel+1 cycles after the new value is presented.
- R10: After reset, every output is 0.
- R11: `frame_stb_o` is a one-cycle pulse that coincides with the last line strobe of each frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Controller run bit |
| disp_on_i | input | 1 | Display enable bit |
| standby_i | input | 1 | Standby: freeze all generated signals |
| div_sel_i | input | 3 | Prescaler select, 2^n division |
| pitch_m1_i | input | 3 | Dots per byte minus one |
| bytes_m1_i | input | 4 | Bytes per line minus one |
| duty_m1_i | input | 7 | Lines per frame minus one |
| cl2_o | output | 1 | Shift clock pulse, one per dot |
| line_stb_o | output | 1 | Line end strobe |
| frame_stb_o | output | 1 | Frame end strobe |
| frame_m_o | output | 1 | Frame alternation level |
| disp_act_o | output | 1 | Effective display enable |

## Verification
The assertions check several properties on every cycle:
- the freeze in standby;
- the quiet outputs after the run bit drops;
- the registered display-enable relation;
- the coincidence of line strobes with shift pulses, and of frame strobes with line strobes;
- the one-cycle width of pulses at divided rates;
- the rule that the frame level rises only on a frame strobe.

Some behaviour depends on counts over many cycles, so only the bench scenarios can show it. These are the exact line length for each clamped pitch and byte count, the number of lines per frame after duty clamping, the period at each prescaler setting, and the restart latency after a change of division.

// File: rtl/lft_pkg.sv
package lft_pkg;
  localparam int unsigned PITCH_MIN = 6;
  localparam int unsigned PITCH_MAX = 8;
  localparam int unsigned BYTES_MIN = 2;
  localparam int unsigned BYTES_MAX = 10;
  localparam int unsigned DUTY_MIN  = 2;
  localparam int unsigned DUTY_MAX  = 65;
  localparam int unsigned DOTS_MAX  = PITCH_MAX * BYTES_MAX;

  function automatic int unsigned clamp_range(int unsigned v, int unsigned lo, int unsigned hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // pitch outside the legal set falls back to the widest value
  function automatic int unsigned pitch_of(int unsigned field_m1);
    if (field_m1 + 1 >= PITCH_MIN && field_m1 + 1 <= PITCH_MAX) return field_m1 + 1;
    return PITCH_MAX;
  endfunction
endpackage

// File: rtl/lft_prescaler.sv
module lft_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             step_c,
  output logic             tick_q
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;
  logic [CNT_W:0]   one_sh;
  logic [SEL_W-1:0] sel_q;
  logic             restart;

  always_comb begin
    one_sh  = (CNT_W+1)'(1) << sel;
    mask    = CNT_W'(one_sh - (CNT_W+1)'(1));
    restart = (sel != sel_q) || !run;
    step_c  = !hold && !restart && ((cnt_q & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      sel_q  <= '0;
      tick_q <= 1'b0;
    end else if (!hold) begin
      tick_q <= step_c;
      if (restart) begin
        cnt_q <= '0;
        sel_q <= sel;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lft_wrap_counter.sv
module lft_wrap_counter #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] last,
  output logic         wrap_c,
  output logic         wrap_q
);
  logic [W-1:0] cnt_q;

  // >= so a shrinking limit mid-count still wraps promptly
  always_comb wrap_c = !hold && !clr && step && (cnt_q >= last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else if (!hold) begin
      if (clr) begin
        cnt_q  <= '0;
        wrap_q <= 1'b0;
      end else begin
        wrap_q <= wrap_c;
        if (step) cnt_q <= wrap_c ? '0 : cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
  import lft_pkg::*;
#(
  parameter int DIV_SEL_W = 3,
  parameter int PITCH_W   = 3,
  parameter int BYTES_W   = 4,
  parameter int DUTY_W    = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run_i,
  input  logic                 disp_on_i,
  input  logic                 standby_i,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  input  logic [PITCH_W-1:0]   pitch_m1_i,
  input  logic [BYTES_W-1:0]   bytes_m1_i,
  input  logic [DUTY_W-1:0]    duty_m1_i,
  output logic                 cl2_o,
  output logic                 line_stb_o,
  output logic                 frame_stb_o,
  output logic                 frame_m_o,
  output logic                 disp_act_o
);
  localparam int DOT_W  = $clog2(DOTS_MAX + 1);
  localparam int LINE_W = $clog2(DUTY_MAX + 1);

  logic              hold;
  logic              clr;
  logic              pre_step;
  logic              dot_wrap_c;
  logic              line_wrap_c;
  logic [DOT_W-1:0]  dot_last;
  logic [LINE_W-1:0] line_last;
  logic              m_q;
  logic              act_q;

  assign hold = standby_i;
  assign clr  = !run_i;

  always_comb begin
    int unsigned p, b, d;
    p = pitch_of(int'(pitch_m1_i));
    b = clamp_range(int'(bytes_m1_i) + 1, BYTES_MIN, BYTES_MAX);
    d = clamp_range(int'(duty_m1_i) + 1, DUTY_MIN, DUTY_MAX);
    dot_last  = DOT_W'(p * b - 1);
    line_last = LINE_W'(d - 1);
  end

  lft_prescaler #(.SEL_W(DIV_SEL_W)) pre_i (
    .clk(clk), .rst(rst), .hold(hold), .run(run_i), .sel(div_sel_i),
    .step_c(pre_step), .tick_q(cl2_o)
  );

  lft_wrap_counter #(.W(DOT_W)) dot_i (
    .clk(clk), .rst(rst), .hold(hold), .clr(clr), .step(pre_step),
    .last(dot_last), .wrap_c(dot_wrap_c), .wrap_q(line_stb_o)
  );

  lft_wrap_counter #(.W(LINE_W)) line_i (
    .clk(clk), .rst(rst), .hold(hold), .clr(clr), .step(dot_wrap_c),
    .last(line_last), .wrap_c(line_wrap_c), .wrap_q(frame_stb_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      m_q   <= 1'b0;
      act_q <= 1'b0;
    end else begin
      act_q <= run_i && disp_on_i && !standby_i;
      if (!hold) begin
        if (clr)              m_q <= 1'b0;
        else if (line_wrap_c) m_q <= !m_q;
      end
    end
  end

  assign frame_m_o  = m_q;
  assign disp_act_o = act_q;
endmodule

// File: rtl/lft_checker.sv
module lft_checker #(
  parameter int DIV_SEL_W = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 run_i,
  input logic                 disp_on_i,
  input logic                 standby_i,
  input logic [DIV_SEL_W-1:0] div_sel_i,
  input logic                 cl2_o,
  input logic                 line_stb_o,
  input logic                 frame_stb_o,
  input logic                 frame_m_o,
  input logic                 disp_act_o
);
  AST_STBY_FREEZE: assert property (@(posedge clk) disable iff (rst)
    ($past(standby_i) && !$past(rst)) |-> ($stable(cl2_o) && $stable(line_stb_o) && $stable(frame_stb_o) && $stable(frame_m_o))); // R7
  AST_RUN_LOW_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !standby_i) |=> (!cl2_o && !line_stb_o && !frame_m_o)); // R6
  AST_ACT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (disp_act_o == $past(run_i && disp_on_i && !standby_i))); // R8
  AST_LINE_ON_SHIFT: assert property (@(posedge clk) disable iff (rst)
    line_stb_o |-> cl2_o); // R4
  AST_FRAME_ON_LINE: assert property (@(posedge clk) disable iff (rst)
    frame_stb_o |-> line_stb_o); // R11
  AST_FRAME_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    (frame_stb_o && !standby_i) |=> !frame_stb_o); // R11
  AST_M_RISE_ON_FRAME: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_m_o) |-> frame_stb_o); // R5
  AST_PULSE_NARROW: assert property (@(posedge clk) disable iff (rst)
    (cl2_o && !standby_i && div_sel_i != '0 && $stable(div_sel_i)) |=> !cl2_o); // R1
endmodule

bind lcd_frame_timer lft_checker #(.DIV_SEL_W(DIV_SEL_W)) chk_i (
  .clk(clk), .rst(rst), .run_i(run_i), .disp_on_i(disp_on_i), .standby_i(standby_i),
  .div_sel_i(div_sel_i), .cl2_o(cl2_o), .line_stb_o(line_stb_o),
  .frame_stb_o(frame_stb_o), .frame_m_o(frame_m_o), .disp_act_o(disp_act_o)
);

// File: tb/lcd_frame_timer_tb_top.sv
`timescale 1ns/1ps
module lcd_frame_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run_i = 1'b0, disp_on_i = 1'b0, standby_i = 1'b0;
  logic [2:0] div_sel_i = '0, pitch_m1_i = '0;
  logic [3:0] bytes_m1_i = '0;
  logic [6:0] duty_m1_i = '0;
  logic       cl2_o, line_stb_o, frame_stb_o, frame_m_o, disp_act_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lcd_frame_timer dut_i (
    .clk(clk), .rst(rst), .run_i(run_i), .disp_on_i(disp_on_i), .standby_i(standby_i),
    .div_sel_i(div_sel_i), .pitch_m1_i(pitch_m1_i), .bytes_m1_i(bytes_m1_i),
    .duty_m1_i(duty_m1_i), .cl2_o(cl2_o), .line_stb_o(line_stb_o),
    .frame_stb_o(frame_stb_o), .frame_m_o(frame_m_o), .disp_act_o(disp_act_o)
  );

  function automatic int exp_pitch(int f);
    return (f >= 5 && f <= 7) ? f + 1 : 8;
  endfunction
  function automatic int exp_bytes(int f);
    int v = f + 1;
    return (v < 2) ? 2 : (v > 10) ? 10 : v;
  endfunction
  function automatic int exp_duty(int f);
    int v = f + 1;
    return (v < 2) ? 2 : (v > 65) ? 65 : v;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic restart_cfg(int sel, int p, int b, int d);
    @(negedge clk);
    run_i = 1'b0;
    div_sel_i = 3'(sel); pitch_m1_i = 3'(p); bytes_m1_i = 4'(b); duty_m1_i = 7'(d);
    repeat (2) @(negedge clk);
    run_i = 1'b1;
  endtask

  task automatic wait_for_line(output bit ok);
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (line_stb_o) begin ok = 1; break; end
    end
  endtask

  task automatic meas_line(string req, int exp);
    bit ok;
    int n = 0;
    wait_for_line(ok);
    for (int i = 0; i < 20000 && ok; i++) begin
      @(negedge clk);
      if (cl2_o) n++;
      if (line_stb_o) break;
    end
    check(req, n, exp);
  endtask

  task automatic meas_period(string req, int exp);
    int n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (cl2_o) break;
    end
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      n++;
      if (cl2_o) break;
    end
    check(req, n, exp);
  endtask

  task automatic meas_frame(string req, int exp);
    int n = 0;
    logic m0;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (frame_stb_o) break;
    end
    m0 = frame_m_o;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (line_stb_o) n++;
      if (frame_stb_o) break;
    end
    check(req, n, exp);
    check({req, " M toggles"}, int'(frame_m_o != m0), 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 cl2", int'(cl2_o), 0);
    check("R10 line", int'(line_stb_o), 0);
    check("R10 frame", int'(frame_stb_o), 0);
    check("R10 m", int'(frame_m_o), 0);
    check("R10 act", int'(disp_act_o), 0);
    rst = 1'b0;

    // R2 R3 R4: directed clamps, 1/1 rate
    restart_cfg(0, 4, 0, 3);  meas_line("R2 pitch 4->8, R3 bytes 0->2, R4", 16);
    restart_cfg(0, 5, 15, 3); meas_line("R2 pitch 6, R3 bytes 16->10, R4", 60);
    restart_cfg(0, 7, 9, 3);  meas_line("R4 80 dots", 80);
    restart_cfg(0, 0, 3, 3);  meas_line("R2 pitch 0->8", 32);

    // R1 R4: constrained random geometry and rates
    for (int k = 0; k < 6; k++) begin
      int s = int'($urandom_range(0, 2));
      int p = int'($urandom_range(0, 7));
      int b = int'($urandom_range(0, 15));
      restart_cfg(s, p, b, 3);
      meas_line("R4 random line", exp_pitch(p) * exp_bytes(b));
      if (s != 0) meas_period("R1 random period", 1 << s);
    end
    restart_cfg(7, 5, 1, 3); meas_period("R1 1/128", 128);
    restart_cfg(5, 5, 1, 3); meas_period("R1 1/32", 32);

    // R5 R11: frame lengths with duty clamps
    restart_cfg(0, 5, 1, 1);   meas_frame("R5 R11 duty 2", 2);
    restart_cfg(0, 5, 1, 0);   meas_frame("R5 duty 0->2", exp_duty(0));
    restart_cfg(0, 5, 1, 100); meas_frame("R5 duty 101->65", exp_duty(100));
    restart_cfg(0, 6, 2, 9);   meas_frame("R5 duty 10", 10);

    // R9 prescaler restart latency
    restart_cfg(0, 5, 1, 3);
    repeat (5) @(negedge clk);
    div_sel_i = 3'd3;
    begin
      int n = 0;
      for (int i = 0; i < 1000; i++) begin
        @(negedge clk); n++;
        if (cl2_o) break;
      end
      check("R9 restart sel3", n, 9);
    end
    div_sel_i = 3'd2;
    begin
      int n = 0;
      for (int i = 0; i < 1000; i++) begin
        @(negedge clk); n++;
        if (cl2_o) break;
      end
      check("R9 restart sel2", n, 5);
    end

    // R8 display enable
    disp_on_i = 1'b1;
    @(negedge clk);
    check("R8 act on", int'(disp_act_o), 1);

    // R7 standby freeze (1/2 rate so outputs move)
    restart_cfg(1, 5, 1, 1);
    disp_on_i = 1'b1;
    repeat (37) @(negedge clk);
    standby_i = 1'b1;
    begin
      logic c0 = cl2_o, l0 = line_stb_o, f0 = frame_stb_o, m0 = frame_m_o;
      int bad = 0;
      @(negedge clk);
      check("R8 act low in standby", int'(disp_act_o), 0);
      for (int i = 0; i < 40; i++) begin
        if (cl2_o != c0 || line_stb_o != l0 || frame_stb_o != f0 || frame_m_o != m0) bad++;
        @(negedge clk);
      end
      check("R7 frozen outputs", bad, 0);
    end
    standby_i = 1'b0;
    meas_line("R4 after standby", 12);

    // R6 run low quiets outputs
    restart_cfg(0, 5, 1, 1);
    repeat (30) @(negedge clk);
    run_i = 1'b0;
    @(negedge clk);
    check("R6 cl2", int'(cl2_o), 0);
    check("R6 line", int'(line_stb_o), 0);
    check("R6 m", int'(frame_m_o), 0);
    check("R8 act after run low", int'(disp_act_o), 0);

    finish_run();
  end
endmodule